// File: doc/BRIEF.md
# Segmented Receive Stream Serializer

This block sits behind a wide receive path that delivers up to four 256-bit segments per clock on a 1024-bit bus. The bus cannot be stalled, so every valid segment must be taken in the cycle it appears. Each segment has its own valid, start-of-packet and end-of-packet flags. End-of-packet segments also carry a count of valid bytes. A packet may begin in any segment. It may run past the top segment and continue at segment 0 of a following beat, and one beat may hold several packets.

The block squeezes out the invalid segments of each beat and writes the remaining ones, lowest index first, into a buffer that takes up to four entries per cycle. It then sends them one per cycle on a 256-bit valid/ready output stream, with start, end and byte-count fields. Beats are stored whole and read strictly first-in first-out, so packets leave in arrival order and a later packet can never overtake an earlier one. The number of free buffer slots is output every cycle, so that an outside credit scheme can throttle the sender. Three sticky error flags report buffer overflow, too many packet starts in one beat, and use of the upper segments while both lower segments are idle.

Top module: `seg_rx_serializer`

## Requirements
- R1: After reset, out_valid is 0, free_slots equals DEPTH (16 by default), and err_overflow, err_sop_count and err_upper_only are all 0.
- R2: The valid segments of a beat leave one per accepted output cycle, in ascending segment index, with invalid segments skipped. The first of them is presented in the cycle after the beat is captured.
- R3: Beats leave in arrival order. A packet that continues from segment 3 into segment 0 of the next beat comes out as contiguous entries, with its start and end flags unchanged.
- R4: Input byte counts use 6 bits per segment, with segment i at in_bytes[6*i +: 6], and give the number of valid bytes (1 to 32). On an end-of-packet entry, out_bytes equals the input count. On any other entry it reads 32.
- R5: free_slots equals DEPTH minus the number of stored entries. It changes in the cycle after a write or read, and it rises by exactly 1 after a pop in a cycle with no valid input.
- R6: If a beat holds more valid segments than free_slots, the whole beat is dropped, err_overflow is set and stays set until reset, and the stored entries are not changed.
- R7: A beat with more than 3 segments that are both valid and start-of-packet sets err_sop_count, which stays set until reset. The beat is still stored.
- R8: A beat in which segments 0 and 1 are both invalid but segment 2 or 3 is valid sets err_upper_only, which stays set until reset.
- R9: While out_valid is 1 and out_ready is 0, out_valid, out_data, out_sop, out_eop and out_bytes hold their values.
- R10: Start and end flags on invalid segments have no effect: nothing is stored, free_slots does not change and no error flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 4 | Per-segment valid |
| in_sop | input | 4 | Per-segment start of packet |
| in_eop | input | 4 | Per-segment end of packet |
| in_data | input | 1024 | Segment payloads, segment i at bits 256*i +: 256 |
| in_bytes | input | 24 | Per-segment valid byte count, 6 bits each |
| out_valid | output | 1 | Output entry available |
| out_ready | input | 1 | Consumer accepts the entry |
| out_data | output | 256 | Output segment payload |
| out_sop | output | 1 | Output start of packet |
| out_eop | output | 1 | Output end of packet |
| out_bytes | output | 6 | Valid bytes in the output entry |
| free_slots | output | 5 | Free buffer entries |
| err_overflow | output | 1 | Sticky: a beat was dropped for lack of space |
| err_sop_count | output | 1 | Sticky: more than three packet starts in one beat |
| err_upper_only | output | 1 | Sticky: upper segments used while both lower segments were idle |

## Verification
A wrong compaction index or write pointer shows up in the first entry that leaves after the faulty beat, as a payload or flag that is swapped, repeated or missing. Every entry's payload tag is therefore compared in order. A drifting occupancy count shows in free_slots one cycle after the faulty write or read, and it later causes a false overflow or an extra output. Both are checked right after the fill and again after the drain. Each error flag is checked on the first cycle after the beat that triggers it, and also after the beats that must leave it clear.

// File: rtl/seg_rx_pkg.sv
package seg_rx_pkg;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

   function automatic int unsigned seg_bytes(input int unsigned seg_bits);
      return seg_bits / 8;
   endfunction

endpackage

// File: rtl/seg_rx_compactor.sv
module seg_rx_compactor #(
   parameter int unsigned NUM_SEG = 4,
   parameter int unsigned SEG_W   = 256,
   parameter int unsigned BC_W    = 6,
   localparam int unsigned ENT_W  = SEG_W + 2 + BC_W,
   localparam int unsigned NSEG_W = $clog2(NUM_SEG + 1),
   localparam int unsigned IDX_W  = $clog2(NUM_SEG)
) (
   input  logic [NUM_SEG-1:0]            in_valid,
   input  logic [NUM_SEG-1:0]            in_sop,
   input  logic [NUM_SEG-1:0]            in_eop,
   input  logic [NUM_SEG*SEG_W-1:0]      in_data,
   input  logic [NUM_SEG*BC_W-1:0]       in_bytes,
   output logic [NUM_SEG-1:0][ENT_W-1:0] lane_ent,
   output logic [NSEG_W-1:0]             lane_num
);
   localparam logic [BC_W-1:0] FULL_CNT = BC_W'(seg_rx_pkg::seg_bytes(SEG_W));

   logic [NUM_SEG-1:0][ENT_W-1:0] seg_ent;

   for (genvar i = 0; i < NUM_SEG; i++) begin : g_ent
      logic [BC_W-1:0] cnt;
      assign cnt        = in_eop[i] ? in_bytes[i*BC_W +: BC_W] : FULL_CNT;
      assign seg_ent[i] = {cnt, in_eop[i], in_sop[i], in_data[i*SEG_W +: SEG_W]};
   end

   always_comb begin
      logic [NSEG_W-1:0] pos;
      pos      = '0;
      lane_ent = '0;
      for (int i = 0; i < NUM_SEG; i++) begin
         if (in_valid[i]) begin
            lane_ent[pos[IDX_W-1:0]] = seg_ent[i];
            pos = pos + NSEG_W'(1);
         end
      end
      lane_num = pos;
   end
endmodule

// File: rtl/seg_rx_fifo.sv
module seg_rx_fifo #(
   parameter int unsigned NUM_SEG = 4,
   parameter int unsigned ENT_W   = 264,
   parameter int unsigned DEPTH   = 16,
   localparam int unsigned NSEG_W = $clog2(NUM_SEG + 1),
   localparam int unsigned PTR_W  = $clog2(DEPTH),
   localparam int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NUM_SEG-1:0][ENT_W-1:0] wr_lanes,
   input  logic [NSEG_W-1:0]             wr_num,
   input  logic                          rd_pop,
   output logic [ENT_W-1:0]              rd_ent,
   output logic                          rd_valid,
   output logic [CNT_W-1:0]              free_slots,
   output logic                          wr_drop
);
   logic [ENT_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0] wptr, rptr;
   logic [CNT_W-1:0] used;
   logic             wr_ok;
   logic             pop_ok;

   assign free_slots = CNT_W'(DEPTH) - used;
   assign wr_ok      = CNT_W'(wr_num) <= free_slots;
   assign wr_drop    = !wr_ok;
   assign rd_valid   = used != '0;
   assign pop_ok     = rd_pop && rd_valid;
   assign rd_ent     = mem[rptr];

   always_ff @(posedge clk) begin
      for (int j = 0; j < NUM_SEG; j++) begin
         if (wr_ok && (NSEG_W'(j) < wr_num))
            mem[wptr + PTR_W'(j)] <= wr_lanes[j];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wptr <= '0;
         rptr <= '0;
         used <= '0;
      end else begin
         if (wr_ok)
            wptr <= wptr + PTR_W'(wr_num);
         if (pop_ok)
            rptr <= rptr + PTR_W'(1);
         used <= used + (wr_ok ? CNT_W'(wr_num) : '0) - CNT_W'(pop_ok);
      end
   end
endmodule

// File: rtl/seg_rx_monitor.sv
module seg_rx_monitor #(
   parameter int unsigned NUM_SEG = 4,
   parameter int unsigned MAX_SOP = 3,
   localparam int unsigned NSEG_W = $clog2(NUM_SEG + 1),
   localparam int unsigned HALF   = NUM_SEG / 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SEG-1:0] in_valid,
   input  logic [NUM_SEG-1:0] in_sop,
   input  logic               drop_evt,
   output logic               err_overflow,
   output logic               err_sop_count,
   output logic               err_upper_only
);
   logic [NSEG_W-1:0] n_sop;
   logic              sop_bad;
   logic              upper_bad;

   always_comb begin
      n_sop = '0;
      for (int i = 0; i < NUM_SEG; i++)
         n_sop = n_sop + NSEG_W'(in_valid[i] & in_sop[i]);
   end

   assign sop_bad   = n_sop > NSEG_W'(MAX_SOP);
   assign upper_bad = (in_valid[HALF-1:0] == '0) && (in_valid[NUM_SEG-1:HALF] != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         err_overflow   <= 1'b0;
         err_sop_count  <= 1'b0;
         err_upper_only <= 1'b0;
      end else begin
         err_overflow   <= err_overflow   | drop_evt;
         err_sop_count  <= err_sop_count  | sop_bad;
         err_upper_only <= err_upper_only | upper_bad;
      end
   end
endmodule

// File: rtl/seg_rx_serializer.sv
module seg_rx_serializer #(
   parameter int unsigned NUM_SEG = 4,
   parameter int unsigned SEG_W   = 256,
   parameter int unsigned DEPTH   = 16,
   parameter int unsigned MAX_SOP = 3,
   localparam int unsigned BC_W   = $clog2(SEG_W / 8) + 1,
   localparam int unsigned ENT_W  = SEG_W + 2 + BC_W,
   localparam int unsigned NSEG_W = $clog2(NUM_SEG + 1),
   localparam int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_SEG-1:0]       in_valid,
   input  logic [NUM_SEG-1:0]       in_sop,
   input  logic [NUM_SEG-1:0]       in_eop,
   input  logic [NUM_SEG*SEG_W-1:0] in_data,
   input  logic [NUM_SEG*BC_W-1:0]  in_bytes,
   output logic                     out_valid,
   input  logic                     out_ready,
   output logic [SEG_W-1:0]         out_data,
   output logic                     out_sop,
   output logic                     out_eop,
   output logic [BC_W-1:0]          out_bytes,
   output logic [CNT_W-1:0]         free_slots,
   output logic                     err_overflow,
   output logic                     err_sop_count,
   output logic                     err_upper_only
);
   if (!seg_rx_pkg::is_pow2(DEPTH)) begin : g_bad_depth
      $error("DEPTH must be a power of two");
   end
   if (DEPTH < NUM_SEG) begin : g_small_depth
      $error("DEPTH must hold at least one full beat");
   end
   if ((NUM_SEG < 2) || (NUM_SEG % 2 != 0)) begin : g_bad_nseg
      $error("NUM_SEG must be even and at least 2");
   end
   if ((SEG_W % 8) != 0) begin : g_bad_segw
      $error("SEG_W must be a whole number of bytes");
   end

   logic [NUM_SEG-1:0][ENT_W-1:0] lanes;
   logic [NSEG_W-1:0]             lane_num;
   logic [ENT_W-1:0]              head;
   logic                          drop;

   seg_rx_compactor #(.NUM_SEG(NUM_SEG), .SEG_W(SEG_W), .BC_W(BC_W)) cmp_i (
      .in_valid (in_valid),
      .in_sop   (in_sop),
      .in_eop   (in_eop),
      .in_data  (in_data),
      .in_bytes (in_bytes),
      .lane_ent (lanes),
      .lane_num (lane_num)
   );

   seg_rx_fifo #(.NUM_SEG(NUM_SEG), .ENT_W(ENT_W), .DEPTH(DEPTH)) buf_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_lanes   (lanes),
      .wr_num     (lane_num),
      .rd_pop     (out_ready),
      .rd_ent     (head),
      .rd_valid   (out_valid),
      .free_slots (free_slots),
      .wr_drop    (drop)
   );

   seg_rx_monitor #(.NUM_SEG(NUM_SEG), .MAX_SOP(MAX_SOP)) mon_i (
      .clk            (clk),
      .rst_n          (rst_n),
      .in_valid       (in_valid),
      .in_sop         (in_sop),
      .drop_evt       (drop),
      .err_overflow   (err_overflow),
      .err_sop_count  (err_sop_count),
      .err_upper_only (err_upper_only)
   );

   assign out_data  = head[SEG_W-1:0];
   assign out_sop   = head[SEG_W];
   assign out_eop   = head[SEG_W+1];
   assign out_bytes = head[ENT_W-1 -: BC_W];
endmodule

// File: rtl/seg_rx_serializer_chk.sv
module seg_rx_serializer_chk #(
   parameter int unsigned NUM_SEG = 4,
   parameter int unsigned SEG_W   = 256,
   parameter int unsigned DEPTH   = 16,
   parameter int unsigned MAX_SOP = 3,
   localparam int unsigned BC_W   = $clog2(SEG_W / 8) + 1,
   localparam int unsigned CNT_W  = $clog2(DEPTH + 1),
   localparam int unsigned HALF   = NUM_SEG / 2
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_SEG-1:0] in_valid,
   input logic [NUM_SEG-1:0] in_sop,
   input logic               out_valid,
   input logic               out_ready,
   input logic [SEG_W-1:0]   out_data,
   input logic               out_sop,
   input logic               out_eop,
   input logic [BC_W-1:0]    out_bytes,
   input logic [CNT_W-1:0]   free_slots,
   input logic               err_overflow,
   input logic               err_sop_count,
   input logic               err_upper_only
);
   AST_FREE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      free_slots <= CNT_W'(DEPTH)); // R5
   AST_FREE_POP: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid == '0 && out_valid && out_ready) |=> free_slots == $past(free_slots) + CNT_W'(1)); // R5
   AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(in_valid) > int'(free_slots)) |=> err_overflow); // R6
   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      err_overflow |=> err_overflow); // R6
   AST_SOP_SET: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(in_valid & in_sop) > MAX_SOP) |=> err_sop_count); // R7
   AST_SOP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      err_sop_count |=> err_sop_count); // R7
   AST_UPPER_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid[HALF-1:0] == '0 && in_valid[NUM_SEG-1:HALF] != '0) |=> err_upper_only); // R8
   AST_UPPER_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      err_upper_only |=> err_upper_only); // R8
   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_sop)
                                     && $stable(out_eop) && $stable(out_bytes))); // R9
endmodule

bind seg_rx_serializer seg_rx_serializer_chk #(
   .NUM_SEG(NUM_SEG), .SEG_W(SEG_W), .DEPTH(DEPTH), .MAX_SOP(MAX_SOP)
) chk_i (.*);

// File: tb/seg_rx_serializer_tb_top.sv
`timescale 1ns/1ps
module seg_rx_serializer_tb_top;
   localparam int NS    = 4;
   localparam int SW    = 256;
   localparam int DEP   = 16;
   localparam int BW    = 6;
   localparam int EW    = SW + 2 + BW;
   localparam int CW    = 5;

   // table entry: {valid[3:0], sop[3:0], eop[3:0]}, bit 0 of each field = segment 0
   localparam logic [11:0] BEATS [4] = '{
      12'b1111_1001_0100,   // pkt A in seg0..2, pkt B starts in seg3
      12'b0111_0110_0011,   // B ends seg0 (wrap), C single seg1, D starts seg2
      12'b1010_0000_1000,   // D continues seg1, ends seg3
      12'b0011_0001_0010    // E in seg0..1
   };

   logic              clk = 1'b0;
   logic              rst_n;
   logic [NS-1:0]     in_valid, in_sop, in_eop;
   logic [NS*SW-1:0]  in_data;
   logic [NS*BW-1:0]  in_bytes;
   logic              out_valid, out_ready;
   logic [SW-1:0]     out_data;
   logic              out_sop, out_eop;
   logic [BW-1:0]     out_bytes;
   logic [CW-1:0]     free_slots;
   logic              err_overflow, err_sop_count, err_upper_only;

   int n_chk = 0;
   int n_fail = 0;
   logic [EW-1:0] exp_q [$];

   always #2 clk = ~clk;

   seg_rx_serializer #(.NUM_SEG(NS), .SEG_W(SW), .DEPTH(DEP), .MAX_SOP(3)) dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop),
      .in_data(in_data), .in_bytes(in_bytes), .out_valid(out_valid), .out_ready(out_ready),
      .out_data(out_data), .out_sop(out_sop), .out_eop(out_eop), .out_bytes(out_bytes),
      .free_slots(free_slots), .err_overflow(err_overflow), .err_sop_count(err_sop_count),
      .err_upper_only(err_upper_only)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [SW-1:0] seg_pay(input logic [7:0] tag, input int s);
      return SW'({16'hD00D, tag, 8'(s)});
   endfunction

   function automatic logic [BW-1:0] seg_cnt(input logic [7:0] tag, input int s);
      return BW'((int'(tag) * 4 + s) % 32 + 1);
   endfunction

   task automatic do_reset();
      rst_n = 1'b0; in_valid = '0; in_sop = '0; in_eop = '0;
      in_data = '0; in_bytes = '0; out_ready = 1'b0;
      exp_q.delete();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // drives one beat from the current negedge; the next call or idle() ends it
   task automatic drive_beat(input logic [3:0] v, input logic [3:0] s, input logic [3:0] e,
                             input logic [7:0] tag, input bit stored);
      @(negedge clk);
      in_valid = v; in_sop = s; in_eop = e;
      for (int i = 0; i < NS; i++) begin
         in_data[i*SW +: SW]  = seg_pay(tag, i);
         in_bytes[i*BW +: BW] = seg_cnt(tag, i);
         if (stored && v[i])
            exp_q.push_back({(e[i] ? seg_cnt(tag, i) : BW'(32)), e[i], s[i], seg_pay(tag, i)});
      end
   endtask

   task automatic idle();
      @(negedge clk);
      in_valid = '0; in_sop = '0; in_eop = '0;
   endtask

   task automatic drain(input int n, input string req);
      out_ready = 1'b1;
      for (int k = 0; k < n; k++) begin
         logic [EW-1:0] e;
         e = exp_q.pop_front();
         chk(out_valid && out_data == e[SW-1:0] && out_sop == e[SW] && out_eop == e[SW+1]
             && out_bytes == e[EW-1 -: BW], req,
             {out_bytes, out_eop, out_sop, out_data[55:0]},
             {e[EW-1 -: BW], e[SW+1], e[SW], e[55:0]});
         @(negedge clk);
      end
      out_ready = 1'b0;
   endtask

   initial begin
      #400000;
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      do_reset();
      @(negedge clk);
      // R1 reset state
      chk(out_valid == 1'b0, "R1 out_valid", 64'(out_valid), 64'd0);
      chk(free_slots == CW'(DEP), "R1 free_slots", 64'(free_slots), 64'(DEP));
      chk({err_overflow, err_sop_count, err_upper_only} == 3'b000, "R1 flags",
          64'({err_overflow, err_sop_count, err_upper_only}), 64'd0);

      // table walk: R2 / R3 / R4
      for (int b = 0; b < 4; b++)
         drive_beat(BEATS[b][11:8], BEATS[b][7:4], BEATS[b][3:0], 8'(b), 1'b1);
      idle();
      chk(free_slots == CW'(DEP - 11), "R5 after fill", 64'(free_slots), 64'(DEP - 11));
      // R9: output held while not ready
      begin
         logic [SW-1:0] held;
         held = out_data;
         @(negedge clk);
         chk(out_valid && out_data == held && out_data == exp_q[0][SW-1:0], "R9 hold",
             out_data[63:0], exp_q[0][63:0]);
      end
      drain(11, "R2 R3 R4 order/framing/bytes");
      chk(out_valid == 1'b0 && free_slots == CW'(DEP), "R5 after drain",
          64'({out_valid, free_slots}), 64'(DEP));

      // R10: flags on invalid segments ignored
      drive_beat(4'b0000, 4'b1111, 4'b1111, 8'h40, 1'b1);
      idle();
      chk(out_valid == 1'b0 && free_slots == CW'(DEP), "R10 no store",
          64'({out_valid, free_slots}), 64'(DEP));
      chk({err_overflow, err_sop_count, err_upper_only} == 3'b000, "R10 no flags",
          64'({err_overflow, err_sop_count, err_upper_only}), 64'd0);

      // R6: overflow drops whole beat
      for (int b = 0; b < 4; b++)
         drive_beat(4'b1111, 4'b0001, 4'b1000, 8'(8'h10 + b), 1'b1);
      drive_beat(4'b0001, 4'b0001, 4'b0001, 8'h77, 1'b0);
      idle();
      chk(err_overflow == 1'b1 && free_slots == '0, "R6 overflow flag",
          64'({err_overflow, free_slots}), 64'({1'b1, 5'd0}));
      drain(16, "R6 stored entries intact");
      chk(out_valid == 1'b0, "R6 dropped beat absent", 64'(out_valid), 64'd0);
      // R5: pop with no input raises free by one (checked via fill of one then drain)
      drive_beat(4'b0011, 4'b0001, 4'b0010, 8'h21, 1'b1);
      idle();
      chk(free_slots == CW'(DEP - 2), "R5 two stored", 64'(free_slots), 64'(DEP - 2));
      drain(1, "R2 partial drain");
      chk(free_slots == CW'(DEP - 1) && err_overflow, "R5 pop +1 / R6 sticky",
          64'({err_overflow, free_slots}), 64'({1'b1, 5'(DEP - 1)}));
      drain(1, "R2 partial drain");

      // R7: four starts in a beat
      drive_beat(4'b1111, 4'b1111, 4'b1111, 8'h30, 1'b1);
      idle();
      chk(err_sop_count == 1'b1 && free_slots == CW'(DEP - 4), "R7 flag and stored",
          64'({err_sop_count, free_slots}), 64'({1'b1, 5'(DEP - 4)}));
      chk(err_upper_only == 1'b0, "R8 clear on legal beat", 64'(err_upper_only), 64'd0);
      drain(4, "R7 beat content");

      // R8: upper-only usage
      do_reset();
      drive_beat(4'b1100, 4'b0100, 4'b1000, 8'h50, 1'b1);
      idle();
      chk(err_upper_only == 1'b1 && err_sop_count == 1'b0 && err_overflow == 1'b0, "R8 flag",
          64'({err_upper_only, err_sop_count, err_overflow}), 64'b100);
      drain(2, "R8 beat content");
      chk(err_upper_only == 1'b1, "R8 sticky", 64'(err_upper_only), 64'd1);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule